// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital sequencer for one H-bridge that holds the peak load current below a limit. An external comparator raises an overcurrent flag when the sensed current reaches the limit. The controller then turns off the conducting high-side switch for a programmed number of cycles. The low-side switch of the active diagonal stays on during that time, so the winding current recirculates and decays slowly. When the off-time ends, the high-side switch turns back on and the current rises again.

Every switching event opens a blanking window during which the flag is ignored. Such an event can be the end of an off-time, a return from disable or the end of a direction change. The window masks switching spikes, and it also sets the shortest on-time the loop can produce. A change of the direction input turns all four switches off for a dead-time before the opposite diagonal is driven. The dead-time, blanking and off-time lengths are cycle counts taken from input ports. A status code reports which phase of the sequence is active.

Top module: `fixed_off_chopper`

## Requirements
- R1: While `enable` is low, all four gate outputs are 0.
- R2: When `enable` rises, the next cycle starts a blanking window of max(`blankLen`,1) cycles with the selected diagonal driven, and the drive state follows it.
- R3: The overcurrent flag is ignored during blanking. If the flag is already high when blanking ends, the drive state lasts exactly one cycle before the off-time starts.
- R4: In the drive state, a flag that is high for one cycle after clock edge k reaches the trip logic through a two-flop synchroniser, and the off-time state starts at edge k+3. During the off-time, only the low-side switch of the active diagonal is on.
- R5: The off-time lasts max(`offLen`,1) cycles and is followed by a new blanking window. A flag that arrives during the off-time neither extends it nor causes a trip afterwards.
- R6: `phase`=1 drives `hiA` and `loB` (gate code {hiA,loA,hiB,loB} = 4'b1001). `phase`=0 drives `hiB` and `loA` (4'b0110). The off-time code is 4'b0001 or 4'b0100, respectively.
- R7: A change of `phase` during blanking, drive or off-time enters the dead-time state at the next edge. All gates stay off for max(`deadLen`,1) cycles, then blanking starts with the new diagonal.
- R8: A length of zero is treated as one cycle.
- R9: The three lengths are captured only while the block is in the disabled state. Changes while it is enabled have no effect on any duration.
- R10: The high-side and low-side switches of one leg are never on together.
- R11: `state` encodes 0 = disabled, 1 = dead-time, 2 = blanking, 3 = drive, 4 = off-time.
- R12: When `enable` is low at a clock edge, the block is in the disabled state after that edge, whatever state it was in before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Bridge enable |
| phase | input | 1 | Direction, selects the diagonal |
| ocFlag | input | 1 | Asynchronous overcurrent comparator flag |
| deadLen | input | CNT_W | Dead-time length in cycles |
| blankLen | input | CNT_W | Blanking length in cycles |
| offLen | input | CNT_W | Off-time length in cycles |
| hiA | output | 1 | Leg A high-side gate enable |
| loA | output | 1 | Leg A low-side gate enable |
| hiB | output | 1 | Leg B high-side gate enable |
| loB | output | 1 | Leg B low-side gate enable |
| state | output | 3 | Sequencer state code |

## Verification
The bench builds the block with its defaults: CNT_W = 16 and SYNC_STAGES = 2. It programs short lengths (0 to 5 cycles, and 9 for the resampling test) so that every state duration can be counted cycle by cycle. The zero lengths exercise the one-cycle floor of each timer. A flag held high through blanking exposes the one-cycle minimum on-time, and the two synchroniser stages fix the exact trip edge that the bench samples.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    ST_OFFLINE = 3'd0,
    ST_DEAD    = 3'd1,
    ST_BLANK   = 3'd2,
    ST_DRIVE   = 3'd3,
    ST_COAST   = 3'd4
  } chopState_e;

  // control -> datapath
  typedef struct packed {
    logic loadDead;
    logic loadBlank;
    logic loadCoast;
    logic captureLens;
    logic latchPhase;
  } chopStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic cntDone;
    logic trip;
    logic phaseEdge;
    logic phaseAct;
  } chopFlags_t;

endpackage

// File: rtl/chop_dp.sv
module chop_dp
  import chop_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseIn,
  input  logic             ocIn,
  input  logic [CNT_W-1:0] deadLenIn,
  input  logic [CNT_W-1:0] blankLenIn,
  input  logic [CNT_W-1:0] offLenIn,
  input  chopStrobe_t      strobe,
  output chopFlags_t       flags
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] deadQ, blankQ, offQ;
  logic [CNT_W-1:0] deadSrc, blankSrc, offSrc, loadVal, cntQ;
  logic             phaseActQ;
  logic             tripSync;

  // overcurrent synchroniser
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= 1'b0;
        else       syncQ <= ocIn;
      assign tripSync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ocIn};
      assign tripSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // length capture, only while offline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deadQ  <= ONE;
      blankQ <= ONE;
      offQ   <= ONE;
    end else if (strobe.captureLens) begin
      deadQ  <= deadLenIn;
      blankQ <= blankLenIn;
      offQ   <= offLenIn;
    end
  end

  assign deadSrc  = strobe.captureLens ? deadLenIn  : deadQ;
  assign blankSrc = strobe.captureLens ? blankLenIn : blankQ;
  assign offSrc   = strobe.captureLens ? offLenIn   : offQ;

  always_comb begin
    if (strobe.loadDead)       loadVal = deadSrc;
    else if (strobe.loadBlank) loadVal = blankSrc;
    else                       loadVal = offSrc;
    // zero length behaves as one cycle
    if (loadVal != ZERO) loadVal = loadVal - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cntQ <= ZERO;
    else if (strobe.loadDead || strobe.loadBlank || strobe.loadCoast)
      cntQ <= loadVal;
    else if (cntQ != ZERO)
      cntQ <= cntQ - ONE;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  phaseActQ <= 1'b0;
    else if (strobe.latchPhase) phaseActQ <= phaseIn;

  assign flags.cntDone   = (cntQ == ZERO);
  assign flags.trip      = tripSync;
  assign flags.phaseEdge = (phaseIn != phaseActQ);
  assign flags.phaseAct  = phaseActQ;

  // R9: lengths frozen while not offline
  p_len_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureLens |=> ($stable(deadQ) && $stable(blankQ) && $stable(offQ)));

  // R8: an idle counter stays at its floor
  p_cnt_floor_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == ZERO && !strobe.loadDead && !strobe.loadBlank && !strobe.loadCoast)
      |=> cntQ == ZERO);

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  chopFlags_t  flags,
  output chopStrobe_t strobe,
  output chopState_e  stateQ,
  output logic        hiA,
  output logic        loA,
  output logic        hiB,
  output logic        loB
);

  chopState_e stNext;
  logic       driving, coasting;

  always_comb begin
    stNext = stateQ;
    if (!enable) begin
      stNext = ST_OFFLINE;
    end else begin
      unique case (stateQ)
        ST_OFFLINE: stNext = ST_BLANK;
        ST_DEAD:    if (flags.cntDone) stNext = ST_BLANK;
        ST_BLANK:   if (flags.phaseEdge)    stNext = ST_DEAD;
                    else if (flags.cntDone) stNext = ST_DRIVE;
        ST_DRIVE:   if (flags.phaseEdge)    stNext = ST_DEAD;
                    else if (flags.trip)    stNext = ST_COAST;
        ST_COAST:   if (flags.phaseEdge)    stNext = ST_DEAD;
                    else if (flags.cntDone) stNext = ST_BLANK;
        default:    stNext = ST_OFFLINE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) stateQ <= ST_OFFLINE;
    else       stateQ <= stNext;

  always_comb begin
    strobe.loadDead    = (stNext == ST_DEAD)  && (stateQ != ST_DEAD);
    strobe.loadBlank   = (stNext == ST_BLANK) && (stateQ != ST_BLANK);
    strobe.loadCoast   = (stNext == ST_COAST) && (stateQ != ST_COAST);
    strobe.captureLens = (stateQ == ST_OFFLINE);
    strobe.latchPhase  = (stNext == ST_BLANK) &&
                         (stateQ == ST_OFFLINE || stateQ == ST_DEAD);
  end

  assign driving  = (stateQ == ST_BLANK) || (stateQ == ST_DRIVE);
  assign coasting = (stateQ == ST_COAST);
  assign hiA = driving && flags.phaseAct;
  assign loB = (driving || coasting) && flags.phaseAct;
  assign hiB = driving && !flags.phaseAct;
  assign loA = (driving || coasting) && !flags.phaseAct;

  // R10: no shoot-through on either leg
  p_leg_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(hiA && loA) && !(hiB && loB));

  // R12: disable wins from any state
  p_disable_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> stateQ == ST_OFFLINE);

  // R3: a trip during blanking never reaches the off-time
  p_blank_no_trip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BLANK && enable && !flags.phaseEdge) |=> stateQ != ST_COAST);

  // R5: off-time is left only on timer expiry, a phase edge or disable
  p_coast_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_COAST && enable && !flags.phaseEdge && !flags.cntDone)
      |=> stateQ == ST_COAST);

  // R7: dead-time keeps every gate off
  p_dead_dark_r7: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_DEAD |-> !(hiA || loA || hiB || loB));

endmodule

// File: rtl/fixed_off_chopper.sv
module fixed_off_chopper
  import chop_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             phase,
  input  logic             ocFlag,
  input  logic [CNT_W-1:0] deadLen,
  input  logic [CNT_W-1:0] blankLen,
  input  logic [CNT_W-1:0] offLen,
  output logic             hiA,
  output logic             loA,
  output logic             hiB,
  output logic             loB,
  output logic [2:0]       state
);

  chopStrobe_t strobe;
  chopFlags_t  flags;
  chopState_e  stateQ;

  chop_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .phaseIn    (phase),
    .ocIn       (ocFlag),
    .deadLenIn  (deadLen),
    .blankLenIn (blankLen),
    .offLenIn   (offLen),
    .strobe     (strobe),
    .flags      (flags)
  );

  chop_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .flags  (flags),
    .strobe (strobe),
    .stateQ (stateQ),
    .hiA    (hiA),
    .loA    (loA),
    .hiB    (hiB),
    .loB    (loB)
  );

  assign state = stateQ;

  // R1: offline means dark outputs
  p_offline_dark_r1: assert property (@(posedge clk) disable iff (!rstN)
    state == 3'd0 |-> !(hiA || loA || hiB || loB));

endmodule

// File: tb/sim_fixed_off_chopper.sv
`timescale 1ns/1ps
module sim_fixed_off_chopper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        phase = 1'b1;
  logic        ocFlag = 1'b0;
  logic [15:0] deadLen = 16'd1;
  logic [15:0] blankLen = 16'd1;
  logic [15:0] offLen = 16'd1;
  logic        hiA, loA, hiB, loB;
  logic [2:0]  state;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fixed_off_chopper u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .phase(phase), .ocFlag(ocFlag),
    .deadLen(deadLen), .blankLen(blankLen), .offLen(offLen),
    .hiA(hiA), .loA(loA), .hiB(hiB), .loB(loB), .state(state)
  );

  function automatic int gates();
    return {hiA, loA, hiB, loB};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runLen(input int s, output int n);
    n = 0;
    while (state == s && n < 2000) begin
      n++;
      tick();
    end
  endtask

  task automatic waitFor(input int s);
    for (int i = 0; i < 2000 && state != s; i++) tick();
  endtask

  task automatic startup(input int bl, input int ol, input int dl, input bit ph);
    enable = 1'b0;
    blankLen = 16'(bl);
    offLen = 16'(ol);
    deadLen = 16'(dl);
    phase = ph;
    tick();
    tick();
    enable = 1'b1;
    tick();
  endtask

  task automatic tripToCoast();
    ocFlag = 1'b1;
    tick();
    ocFlag = 1'b0;
    tick();
    tick();
  endtask

  task automatic tReset();
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
    tick();
    chk(state == 0, "R11 reset state code", state, 0);
    chk(gates() == 0, "R1 outputs off while disabled", gates(), 0);
  endtask

  task automatic tEnable();
    int n;
    startup(4, 5, 3, 1'b1);
    chk(state == 2, "R11 blanking code after enable", state, 2);
    chk(gates() == 9, "R6 phase=1 diagonal in blanking", gates(), 9);
    runLen(2, n);
    chk(n == 4, "R2 blanking length", n, 4);
    chk(state == 3, "R2 drive after blanking", state, 3);
    chk(gates() == 9, "R6 phase=1 diagonal in drive", gates(), 9);
  endtask

  task automatic tTrip();
    int n;
    ocFlag = 1'b1;
    tick();
    ocFlag = 1'b0;
    chk(state == 3, "R4 no trip after one edge", state, 3);
    tick();
    chk(state == 3, "R4 no trip after two edges", state, 3);
    tick();
    chk(state == 4, "R4 off-time at third edge", state, 4);
    chk(gates() == 1, "R4 only low-side B during off-time", gates(), 1);
    runLen(4, n);
    chk(n == 5, "R5 off-time length", n, 5);
    chk(state == 2, "R5 blanking after off-time", state, 2);
  endtask

  task automatic tCoastIgnore();
    int m;
    waitFor(3);
    tripToCoast();
    chk(state == 4, "R5 in off-time", state, 4);
    ocFlag = 1'b1;
    tick();
    ocFlag = 1'b0;
    runLen(4, m);
    chk(m + 1 == 5, "R5 late trip does not extend off-time", m + 1, 5);
    runLen(2, m);
    chk(state == 3, "R5 drive after blanking", state, 3);
    tick();
    tick();
    chk(state == 3, "R5 late trip not carried into drive", state, 3);
  endtask

  task automatic tBlankIgnore();
    int n;
    enable = 1'b0;
    tick();
    ocFlag = 1'b1;
    enable = 1'b1;
    tick();
    chk(state == 2, "R2 blanking after re-enable", state, 2);
    runLen(2, n);
    chk(n == 4, "R3 blanking not cut by flag", n, 4);
    chk(state == 3, "R3 drive reached despite flag", state, 3);
    tick();
    chk(state == 4, "R3 one-cycle minimum on-time", state, 4);
    ocFlag = 1'b0;
    runLen(4, n);
  endtask

  task automatic tPhase();
    int n;
    waitFor(3);
    phase = 1'b0;
    tick();
    chk(state == 1, "R7 dead-time on phase change", state, 1);
    chk(gates() == 0, "R7 all gates off in dead-time", gates(), 0);
    runLen(1, n);
    chk(n == 3, "R7 dead-time length", n, 3);
    chk(state == 2, "R7 blanking after dead-time", state, 2);
    chk(gates() == 6, "R6 phase=0 diagonal", gates(), 6);
    runLen(2, n);
    tripToCoast();
    chk(gates() == 4, "R6 phase=0 off-time keeps low-side A", gates(), 4);
  endtask

  task automatic tZero();
    int n;
    startup(0, 0, 0, 1'b1);
    runLen(2, n);
    chk(n == 1, "R8 zero blanking is one cycle", n, 1);
    phase = 1'b0;
    tick();
    runLen(1, n);
    chk(n == 1, "R8 zero dead-time is one cycle", n, 1);
    runLen(2, n);
    tripToCoast();
    runLen(4, n);
    chk(n == 1, "R8 zero off-time is one cycle", n, 1);
  endtask

  task automatic tSample();
    int n;
    startup(3, 2, 2, 1'b1);
    runLen(2, n);
    chk(n == 3, "R9 blanking uses captured length", n, 3);
    blankLen = 16'd9;
    offLen = 16'd9;
    deadLen = 16'd9;
    tripToCoast();
    runLen(4, n);
    chk(n == 2, "R9 off-time ignores live change", n, 2);
    runLen(2, n);
    chk(n == 3, "R9 blanking ignores live change", n, 3);
  endtask

  task automatic tDisable();
    tripToCoast();
    chk(state == 4, "R12 in off-time before disable", state, 4);
    enable = 1'b0;
    tick();
    chk(state == 0, "R12 disabled after one edge", state, 0);
    chk(gates() == 0, "R1 gates off after disable", gates(), 0);
  endtask

  initial begin
    tReset();
    tEnable();
    tTrip();
    tCoastIgnore();
    tBlankIgnore();
    tPhase();
    tZero();
    tSample();
    tDisable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule